// File: doc/BRIEF.md
# External Bus Read Controller with Ready

This block runs read cycles on an external asynchronous memory bus, one zone, paced by a transaction clock. When a read request arrives while the controller is idle, it drives the request address onto the bus, pulls the zone chip-select low and steps through a lead phase and a strobe phase. During the strobe phase the read strobe is held low. At the end of that phase a ready input from the memory may stretch the strobe. Read data is taken on the edge that releases the strobe. An optional trail phase keeps chip-select low for a few more cycles. Then the bus returns to idle, and the address stays on the bus until the next request.

The lead length, strobe length, trail length and ready mode are taken from configuration inputs when a request is accepted. Ready can be ignored, sampled directly on the clock edge (synchronous mode), or passed through a two-flop synchronizer (asynchronous mode). In asynchronous mode the raw input is sampled two cycles ahead of the decision edge, so the synchronizer delay overlaps the strobe instead of lengthening it.

The state machine has four states. `ST_IDLE` has chip-select high and the strobe high. `ST_LEAD` has chip-select low and the strobe high. `ST_STROBE` has both low. `ST_TRAIL` has chip-select low and the strobe high. The transitions are:
- IDLE to LEAD on an accepted request with a nonzero lead.
- IDLE to STROBE on an accepted request with a zero lead.
- LEAD to STROBE when the lead count expires.
- STROBE to TRAIL or STROBE to IDLE on a ready decision, depending on whether the trail count is nonzero.
- TRAIL to IDLE when the trail count expires.

Top module: `xbus_rd_ctrl`

## Requirements
- R1: Reset sets the outputs to bus_cs_n=1, bus_rd_n=1, busy=0 and rd_valid=0, and sets bus_addr to 0. A reset in the middle of an access returns the bus to this idle state at once.
- R2: A request (rd_req=1) sampled while busy=0 is accepted. From the next cycle on, bus_cs_n=0, busy=1 and bus_addr equals the requested address. bus_rd_n stays high for exactly LEAD cycles (cfg_lead, 0 to 15) before it goes low.
- R3: With cfg_rdy_mode=2'b00 (ready ignored), bus_rd_n is low for exactly ACTIVE cycles, whatever the value of bus_ready.
- R4: With cfg_rdy_mode=2'b01 or 2'b11 (synchronous), bus_ready is sampled directly at edge LEAD+ACTIVE+n-1 after acceptance, for n=1,2,…. The first sample found high ends the strobe at that edge. Each sample found low adds one strobe cycle.
- R5: With cfg_rdy_mode=2'b10 (asynchronous), bus_ready passes through two flops. Raw sample n is taken at edge LEAD+ACTIVE-3+n after acceptance. The strobe ends two edges after the first raw sample found high, and never before edge LEAD+ACTIVE.
- R6: Read data is captured on the edge where bus_rd_n returns high. rd_valid is high for exactly one cycle, the first cycle with the strobe high, with rd_data holding the captured word.
- R7: After the strobe rises, bus_cs_n stays low for exactly TRAIL cycles (cfg_trail, 0 to 3) and then goes high. busy is the inverse of bus_cs_n, and the strobe is never low while chip-select is high.
- R8: While chip-select is high, bus_addr keeps the last address it drove.
- R9: A request made while busy=1 is dropped. It is not queued and does not change bus_addr.
- R10: An ACTIVE of 0 is treated as 1. In asynchronous mode, LEAD=0 with ACTIVE below 2 is treated as ACTIVE=2.
- R11: The configuration is captured at acceptance. Changing the configuration inputs during an access does not change that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transaction clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read request, accepted when idle |
| rd_addr | input | AW | Address for the requested read |
| cfg_lead | input | CW | Lead phase length in cycles |
| cfg_active | input | CW | Minimum strobe phase length in cycles |
| cfg_trail | input | TW | Trail phase length in cycles |
| cfg_rdy_mode | input | 2 | 00 ignore, 01/11 synchronous, 10 asynchronous |
| bus_ready | input | 1 | Ready from the external device |
| bus_din | input | DW | Read data from the external bus |
| bus_addr | output | AW | External address bus |
| bus_cs_n | output | 1 | Zone chip-select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| rd_data | output | DW | Captured read word |
| rd_valid | output | 1 | One-cycle pulse marking rd_data as new |
| busy | output | 1 | High from acceptance to the end of the trail phase |

## Verification
A wrong state or a wrong phase count shows at the ports in the same cycle. Chip-select falls or rises one cycle off, the strobe starts or ends one cycle off, or rd_valid lands where the strobe is not rising. The bench therefore counts lead, strobe and trail cycles for each access and compares them with lengths computed from the configuration and from the cycle in which ready rises. A synchronizer stage added or removed in the ready path changes the strobe length by one cycle for every asynchronous access where ready arrives late. A capture on the wrong edge returns the idle-bus data word instead of the addressed one.

// File: rtl/xbus_rd_pkg.sv
package xbus_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LEAD   = 2'd1,
        ST_STROBE = 2'd2,
        ST_TRAIL  = 2'd3
    } rd_state_e;

    typedef enum logic [1:0] {
        RDY_OFF      = 2'b00,
        RDY_SYNC     = 2'b01,
        RDY_ASYNC    = 2'b10,
        RDY_SYNC_ALT = 2'b11
    } rdy_mode_e;

    localparam int unsigned RDY_SYNC_STAGES = 2;

endpackage

// File: rtl/xbus_cfg_latch.sv
module xbus_cfg_latch
    import xbus_rd_pkg::*;
#(
    parameter int CW = 4,
    parameter int TW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] lead_in,
    input  logic [CW-1:0] active_in,
    input  logic [TW-1:0] trail_in,
    input  logic [1:0]    mode_in,
    output logic [CW-1:0] lead_c,
    output logic [CW-1:0] active_c,
    output logic [CW-1:0] active_q,
    output logic [TW-1:0] trail_q,
    output rdy_mode_e     mode_q
);

    rdy_mode_e mode_c;

    // R10: clamp the strobe length to the legal minimum for the chosen mode
    always_comb begin
        mode_c   = rdy_mode_e'(mode_in);
        lead_c   = lead_in;
        active_c = (active_in == '0) ? CW'(1) : active_in;
        if (mode_c == RDY_ASYNC && lead_in == '0 && active_c < CW'(2)) begin
            active_c = CW'(2);
        end
    end

    // R11: settings are frozen at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= CW'(1);
            trail_q  <= '0;
            mode_q   <= RDY_OFF;
        end else if (load) begin
            active_q <= active_c;
            trail_q  <= trail_in;
            mode_q   <= mode_c;
        end
    end

endmodule

// File: rtl/xbus_rdy_sampler.sv
module xbus_rdy_sampler
    import xbus_rd_pkg::*;
#(
    parameter int STAGES = RDY_SYNC_STAGES
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ready_raw,
    input  rdy_mode_e mode,
    output logic      ready_ok
);

    logic [STAGES-1:0] sync_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= ready_raw;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[s] <= 1'b0;
                    else        sync_q[s] <= sync_q[s-1];
                end
            end
        end
    endgenerate

    always_comb begin
        unique case (mode)
            RDY_OFF:   ready_ok = 1'b1;
            RDY_ASYNC: ready_ok = sync_q[STAGES-1];
            default:   ready_ok = ready_raw;
        endcase
    end

endmodule

// File: rtl/xbus_phase_cnt.sv
module xbus_phase_cnt #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q > CW'(1)) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign last = (cnt_q <= CW'(1));

endmodule

// File: rtl/xbus_rd_ctrl.sv
module xbus_rd_ctrl
    import xbus_rd_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 4,
    parameter int TW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    input  logic [CW-1:0] cfg_lead,
    input  logic [CW-1:0] cfg_active,
    input  logic [TW-1:0] cfg_trail,
    input  logic [1:0]    cfg_rdy_mode,
    input  logic          bus_ready,
    input  logic [DW-1:0] bus_din,
    output logic [AW-1:0] bus_addr,
    output logic          bus_cs_n,
    output logic          bus_rd_n,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic          busy
);

    rd_state_e     state_q, state_d;
    logic          accept, finish;
    logic          cnt_load, cnt_last, ready_ok;
    logic [CW-1:0] cnt_val;
    logic [CW-1:0] lead_c, active_c, active_q;
    logic [TW-1:0] trail_q;
    rdy_mode_e     mode_q;

    xbus_cfg_latch #(.CW(CW), .TW(TW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .lead_in   (cfg_lead),
        .active_in (cfg_active),
        .trail_in  (cfg_trail),
        .mode_in   (cfg_rdy_mode),
        .lead_c    (lead_c),
        .active_c  (active_c),
        .active_q  (active_q),
        .trail_q   (trail_q),
        .mode_q    (mode_q)
    );

    xbus_rdy_sampler #(.STAGES(RDY_SYNC_STAGES)) u_rdy (
        .clk       (clk),
        .rst_n     (rst_n),
        .ready_raw (bus_ready),
        .mode      (mode_q),
        .ready_ok  (ready_ok)
    );

    xbus_phase_cnt #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .last     (cnt_last)
    );

    // next-state and counter-load logic
    always_comb begin
        state_d  = state_q;
        accept   = 1'b0;
        finish   = 1'b0;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (rd_req) begin
                    accept   = 1'b1;
                    cnt_load = 1'b1;
                    if (lead_c != '0) begin
                        state_d = ST_LEAD;
                        cnt_val = lead_c;
                    end else begin
                        state_d = ST_STROBE;
                        cnt_val = active_c;
                    end
                end
            end
            ST_LEAD: begin
                if (cnt_last) begin
                    state_d  = ST_STROBE;
                    cnt_load = 1'b1;
                    cnt_val  = active_q;
                end
            end
            ST_STROBE: begin
                if (cnt_last && ready_ok) begin
                    finish   = 1'b1;
                    cnt_load = 1'b1;
                    cnt_val  = CW'(trail_q);
                    state_d  = (trail_q != '0) ? ST_TRAIL : ST_IDLE;
                end
            end
            ST_TRAIL: begin
                if (cnt_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // bus controls decoded from the state
    always_comb begin
        bus_cs_n = (state_q == ST_IDLE);
        bus_rd_n = (state_q != ST_STROBE);
        busy     = (state_q != ST_IDLE);
    end

    // address hold, data capture and valid pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_addr <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= finish;
            if (accept) bus_addr <= rd_addr;
            if (finish) rd_data  <= bus_din;
        end
    end

endmodule

// File: rtl/xbus_rd_ctrl_chk.sv
module xbus_rd_ctrl_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_req,
    input logic [AW-1:0] rd_addr,
    input logic [AW-1:0] bus_addr,
    input logic          bus_cs_n,
    input logic          bus_rd_n,
    input logic          rd_valid,
    input logic          busy
);

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && rd_req) |=> (!bus_cs_n && bus_addr == $past(rd_addr)));

    assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    assert_valid_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (bus_rd_n && !$past(bus_rd_n)));

    assert_strobe_in_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> !bus_cs_n);

    assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cs_n |-> $stable(bus_addr));

    assert_drop_busy_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_req) |=> $stable(bus_addr));

endmodule

bind xbus_rd_ctrl xbus_rd_ctrl_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .bus_addr (bus_addr),
    .bus_cs_n (bus_cs_n),
    .bus_rd_n (bus_rd_n),
    .rd_valid (rd_valid),
    .busy     (busy)
);

// File: tb/sim_xbus_rd_ctrl.sv
module sim_xbus_rd_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int CW = 4;
    localparam int TW = 2;
    localparam logic [15:0] DATA_KEY = 16'h5A3C;

    // vector: addr[35:20] lead[19:16] active[15:12] trail[11:10] mode[9:8] ready_rise_edge[7:0]
    localparam int NVEC = 12;
    localparam logic [35:0] VEC [NVEC] = '{
        {16'h1234, 4'd2,  4'd3,  2'd1, 2'b00, 8'd50},
        {16'h0001, 4'd0,  4'd1,  2'd0, 2'b00, 8'd50},
        {16'hBEEF, 4'd1,  4'd2,  2'd2, 2'b01, 8'd0},
        {16'h4321, 4'd2,  4'd2,  2'd1, 2'b01, 8'd7},
        {16'h0F0F, 4'd0,  4'd0,  2'd0, 2'b01, 8'd0},
        {16'hA001, 4'd1,  4'd3,  2'd0, 2'b10, 8'd0},
        {16'hA002, 4'd1,  4'd3,  2'd1, 2'b10, 8'd5},
        {16'hA003, 4'd0,  4'd1,  2'd3, 2'b10, 8'd0},
        {16'hC0DE, 4'd3,  4'd1,  2'd2, 2'b11, 8'd6},
        {16'hA004, 4'd2,  4'd2,  2'd0, 2'b10, 8'd3},
        {16'hFFFF, 4'd15, 4'd15, 2'd3, 2'b00, 8'd0},
        {16'h7777, 4'd0,  4'd4,  2'd0, 2'b01, 8'd2}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_req = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [CW-1:0] cfg_lead = '0;
    logic [CW-1:0] cfg_active = '0;
    logic [TW-1:0] cfg_trail = '0;
    logic [1:0]    cfg_rdy_mode = 2'b00;
    logic          bus_ready = 1'b0;
    logic [DW-1:0] bus_din;
    logic [AW-1:0] bus_addr;
    logic          bus_cs_n, bus_rd_n, rd_valid, busy;
    logic [DW-1:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;

    // external memory model: data only driven while the strobe is low
    assign bus_din = bus_rd_n ? 16'hDEAD : (bus_addr ^ DATA_KEY);

    xbus_rd_ctrl #(.AW(AW), .DW(DW), .CW(CW), .TW(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
        .cfg_lead(cfg_lead), .cfg_active(cfg_active), .cfg_trail(cfg_trail),
        .cfg_rdy_mode(cfg_rdy_mode), .bus_ready(bus_ready), .bus_din(bus_din),
        .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
        .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got=%0d expected=%0d", what, got, exp);
        end
    endtask

    // strobe length from R3, R4, R5 and R10
    function automatic int exp_strobe(input int l, input int a, input int m, input int r);
        int aeff, s;
        aeff = (a == 0) ? 1 : a;
        if (m == 2 && l + aeff < 2) aeff = 2 - l;
        if (m == 0) return aeff;
        if (m == 2) begin
            s = (l + aeff - 2 > r) ? l + aeff - 2 : r;
            return s + 2 - l;
        end
        s = (l + aeff > r) ? l + aeff : r;
        return s - l;
    endfunction

    task automatic run_access(input logic [15:0] addr, input int l, input int a,
                              input int t, input int m, input int r);
        int e, lead_n, act_n, cs_cnt, v_n, v_bad, busy_bad, v_data;
        logic prev_rd;
        lead_n = 0; act_n = 0; cs_cnt = 0; v_n = 0; v_bad = 0; busy_bad = 0; v_data = 0;
        @(negedge clk);
        rd_req = 1'b1; rd_addr = addr;
        cfg_lead = CW'(l); cfg_active = CW'(a); cfg_trail = TW'(t);
        cfg_rdy_mode = 2'(m); bus_ready = (r == 0);
        @(posedge clk);
        e = 0; prev_rd = 1'b1;
        for (int guard = 0; guard < 400; guard++) begin
            @(negedge clk);
            if (e == 0) begin
                // R11: scramble the configuration once the access is accepted
                rd_req = 1'b0;
                cfg_lead = 4'd15; cfg_active = 4'd15; cfg_trail = 2'd3;
                cfg_rdy_mode = (m == 0) ? 2'b01 : 2'b00;
            end
            bus_ready = (e + 1 >= r);
            if (rd_valid) begin
                v_n++;
                v_data = int'(rd_data);
                if (!(bus_rd_n && !prev_rd)) v_bad++;
            end
            if (busy == bus_cs_n) busy_bad++;
            if (bus_cs_n) break;
            cs_cnt++;
            if (!bus_rd_n) act_n++;
            else if (act_n == 0) lead_n++;
            prev_rd = bus_rd_n;
            @(posedge clk);
            e++;
        end
        chk($sformatf("R2 lead cycles addr=%h", addr), lead_n, l);
        chk($sformatf("R3/R4/R5/R10/R11 strobe cycles addr=%h mode=%0d", addr, m),
            act_n, exp_strobe(l, a, m, r));
        chk($sformatf("R7 trail cycles addr=%h", addr), cs_cnt - lead_n - act_n, t);
        chk($sformatf("R7 busy tracks chip-select addr=%h", addr), busy_bad, 0);
        chk($sformatf("R6 valid pulse count addr=%h", addr), v_n, 1);
        chk($sformatf("R6 valid on strobe rise addr=%h", addr), v_bad, 0);
        chk($sformatf("R6 captured data addr=%h", addr), v_data, int'(addr ^ DATA_KEY));
        bus_ready = 1'b0;
        repeat (2) @(negedge clk);
        chk($sformatf("R8 address held while idle addr=%h", addr), int'(bus_addr), int'(addr));
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int hold_bad, extra_cs;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 cs_n at reset", int'(bus_cs_n), 1);
        chk("R1 rd_n at reset", int'(bus_rd_n), 1);
        chk("R1 busy at reset", int'(busy), 0);
        chk("R1 valid at reset", int'(rd_valid), 0);
        chk("R1 addr at reset", int'(bus_addr), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            run_access(VEC[i][35:20], int'(VEC[i][19:16]), int'(VEC[i][15:12]),
                       int'(VEC[i][11:10]), int'(VEC[i][9:8]), int'(VEC[i][7:0]));
        end

        // R9: a request during an access is dropped
        hold_bad = 0; extra_cs = 0;
        @(negedge clk);
        rd_req = 1'b1; rd_addr = 16'h1111;
        cfg_lead = 4'd4; cfg_active = 4'd8; cfg_trail = 2'd1; cfg_rdy_mode = 2'b00;
        @(negedge clk);
        rd_req = 1'b0;
        repeat (2) @(negedge clk);
        rd_req = 1'b1; rd_addr = 16'h2222;
        repeat (5) begin
            @(negedge clk);
            if (bus_addr != 16'h1111) hold_bad++;
        end
        rd_req = 1'b0;
        for (int g = 0; g < 40 && !bus_cs_n; g++) @(negedge clk);
        repeat (4) begin
            @(negedge clk);
            if (!bus_cs_n) extra_cs++;
        end
        chk("R9 address unchanged by busy request", hold_bad, 0);
        chk("R9 no queued access after busy request", extra_cs, 0);
        chk("R9 final address", int'(bus_addr), 16'h1111);

        // R1: reset in the middle of an access
        @(negedge clk);
        rd_req = 1'b1; rd_addr = 16'h3333;
        cfg_lead = 4'd2; cfg_active = 4'd8; cfg_trail = 2'd2; cfg_rdy_mode = 2'b00;
        @(negedge clk);
        rd_req = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 strobe low mid access", int'(bus_rd_n), 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 cs_n after mid-access reset", int'(bus_cs_n), 1);
        chk("R1 rd_n after mid-access reset", int'(bus_rd_n), 1);
        chk("R1 busy after mid-access reset", int'(busy), 0);
        chk("R1 addr after mid-access reset", int'(bus_addr), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule